// File: doc/BRIEF.md
# Channel Sample Formatter

This block sits between the capture of one converter channel and the sample stream handed to the rest of the chip. It takes each raw sample, with its valid strobe, and turns it into a 32-bit word. A small control word holds the run-time options: whether the channel forwards samples at all, whether formatting is applied, whether the incoming code is offset binary, and whether the result is sign-extended. A 2-bit packet-size select tells the formatter where the sample's most significant bit sits inside the raw bus.

An edge-select input chooses the clock edge that samples the raw bus. With the rising edge, the output register samples the bus directly. With the falling edge, a falling-edge register samples the bus and the output register takes its result at the next rising edge. In both modes the formatted result appears one rising edge after the sample is taken. A separate flag register reports whether oversampling is active for the programmed ratio.

Top module: `chfmt_top`

## Requirements
- R1: The control word `cfg_q` holds the channel enable in bit 0, the format enable in bit 4, offset binary in bit 5 and sign extension in bit 6. A high `cfg_load` at a rising edge stores `cfg_wdata` there. All other bits read back as zero.
- R2: After a synchronous reset, `cfg_q` is 0x51, `out_valid` is 0, `out_data` is 0 and `os_en` is 0.
- R3: When the format enable is clear, `out_data` equals the raw 32-bit sample. The offset-binary and sign-extension bits have no effect in this case.
- R4: `pkt_sel` sets the packet width W as follows: code 0 gives 20 bits (this code also carries 16-bit data), code 1 gives 24 bits, and codes 2 and 3 give 32 bits. When formatting is on, the sample is taken from raw bits W-1..0.
- R5: With offset binary set, bit W-1 of the packet field is inverted, which turns the field into two's complement.
- R6: With sign extension set, bits 31..W copy the resulting bit W-1. With sign extension clear, bits 31..W are zero.
- R7: With `edge_fall` at 0, a sample is taken at the rising edge. With `edge_fall` at 1, a sample is taken at the falling edge before the rising edge that registers it.
- R8: While the channel enable is clear, `out_valid` stays 0 and no sample reaches `out_data`.
- R9: A sample taken at rising edge k (or at the falling edge just before it) appears with `out_valid` high after edge k, for exactly one cycle per strobe.
- R10: `out_data` holds its last value on every cycle where `out_valid` is low.
- R11: `os_en` is 1 one cycle after `os_ratio` exceeds 1. It is 0 one cycle after `os_ratio` is 0 or 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Store `cfg_wdata` into the control word |
| cfg_wdata | input | 8 | New control word |
| cfg_q | output | 8 | Current control word |
| edge_fall | input | 1 | 0: rising-edge capture, 1: falling-edge capture |
| pkt_sel | input | 2 | Packet size code |
| os_ratio | input | OSR_W | Oversampling ratio |
| os_en | output | 1 | Oversampling active flag |
| raw_valid | input | 1 | Raw sample strobe |
| raw_data | input | DATA_W | Raw sample bus |
| out_valid | output | 1 | Formatted sample strobe |
| out_data | output | DATA_W | Formatted sample |

## Verification
The bench builds the block with DATA_W = 32 and OSR_W = 8. With these values, 20- and 24-bit packets leave upper bits to fill, while a 32-bit packet leaves none, so sign extension becomes a no-op at the top width and the bench can check that case. An 8-bit ratio lets the bench apply ratios 0, 1, 2 and 255 to the oversampling flag. A split drive, with one value before the falling edge and another after it, gives a different result for each edge mode, so the bench can tell the two modes apart.

// File: rtl/chfmt_pkg.sv
package chfmt_pkg;

    localparam int SAMPLE_W  = 32;
    localparam int CFG_W     = 8;
    localparam int NUM_PKT   = 3;

    localparam int BIT_CH_EN = 0;
    localparam int BIT_FMT   = 4;
    localparam int BIT_OBIN  = 5;
    localparam int BIT_SEXT  = 6;

    typedef enum logic [1:0] {
        PKT_20  = 2'd0,
        PKT_24  = 2'd1,
        PKT_32  = 2'd2,
        PKT_RSV = 2'd3
    } pkt_code_e;

    typedef struct packed {
        logic sext;
        logic obin;
        logic fmt_en;
        logic ch_en;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{sext: 1'b1, obin: 1'b0, fmt_en: 1'b1, ch_en: 1'b1};

    typedef struct packed {
        logic                valid;
        logic [SAMPLE_W-1:0] data;
    } sample_t;

    function automatic int pkt_width(input int idx);
        case (idx)
            0:       return 20;
            1:       return 24;
            default: return 32;
        endcase
    endfunction

    function automatic chan_cfg_t cfg_unpack(input logic [CFG_W-1:0] w);
        chan_cfg_t c;
        c.ch_en  = w[BIT_CH_EN];
        c.fmt_en = w[BIT_FMT];
        c.obin   = w[BIT_OBIN];
        c.sext   = w[BIT_SEXT];
        return c;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_pack(input chan_cfg_t c);
        logic [CFG_W-1:0] w;
        w            = '0;
        w[BIT_CH_EN] = c.ch_en;
        w[BIT_FMT]   = c.fmt_en;
        w[BIT_OBIN]  = c.obin;
        w[BIT_SEXT]  = c.sext;
        return w;
    endfunction

endpackage

// File: rtl/chfmt_cfg_reg.sv
module chfmt_cfg_reg
    import chfmt_pkg::*;
#(
    parameter int OSR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [CFG_W-1:0]     wdata,
    input  logic [OSR_W-1:0]     os_ratio,
    output chan_cfg_t            cfg,
    output logic                 os_en
);

    localparam logic [OSR_W-1:0] OSR_ONE = OSR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg   <= CFG_RESET;
            os_en <= 1'b0;
        end else begin
            if (load) begin
                cfg <= cfg_unpack(wdata);
            end
            os_en <= (os_ratio > OSR_ONE);
        end
    end

endmodule

// File: rtl/chfmt_capture.sv
module chfmt_capture #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              edge_fall,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              cap_valid,
    output logic [DATA_W-1:0] cap_data
);

    logic              neg_valid;
    logic [DATA_W-1:0] neg_data;

    always_ff @(negedge clk) begin
        if (rst) begin
            neg_valid <= 1'b0;
            neg_data  <= '0;
        end else begin
            neg_valid <= in_valid;
            neg_data  <= in_data;
        end
    end

    always_comb begin
        if (edge_fall) begin
            cap_valid = neg_valid;
            cap_data  = neg_data;
        end else begin
            cap_valid = in_valid;
            cap_data  = in_data;
        end
    end

endmodule

// File: rtl/chfmt_core.sv
module chfmt_core
    import chfmt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] raw,
    input  chan_cfg_t         cfg,
    input  pkt_code_e         pkt,
    output logic [DATA_W-1:0] fmt_data
);

    logic [NUM_PKT-1:0][DATA_W-1:0] cands;

    for (genvar g = 0; g < NUM_PKT; g++) begin : g_pkt
        localparam int PW = (pkt_width(g) < DATA_W) ? pkt_width(g) : DATA_W;
        logic [DATA_W-1:0] low_mask;
        logic [DATA_W-1:0] cand;
        logic              msb;

        always_comb begin
            for (int i = 0; i < DATA_W; i++) begin
                low_mask[i] = (i < PW);
            end
            msb          = raw[PW-1] ^ cfg.obin;
            cand         = raw & low_mask;
            cand[PW-1]   = msb;
            if (cfg.sext && msb) begin
                cand = cand | ~low_mask;
            end
        end

        assign cands[g] = cand;
    end

    always_comb begin
        if (!cfg.fmt_en) begin
            fmt_data = raw;
        end else begin
            case (pkt)
                PKT_20:  fmt_data = cands[0];
                PKT_24:  fmt_data = cands[1];
                default: fmt_data = cands[2];
            endcase
        end
    end

endmodule

// File: rtl/chfmt_top.sv
module chfmt_top
    import chfmt_pkg::*;
#(
    parameter int DATA_W = SAMPLE_W,
    parameter int OSR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_q,
    input  logic              edge_fall,
    input  logic [1:0]        pkt_sel,
    input  logic [OSR_W-1:0]  os_ratio,
    output logic              os_en,
    input  logic              raw_valid,
    input  logic [DATA_W-1:0] raw_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    chan_cfg_t         cfg_s;
    logic              cap_valid;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] fmt_data;

    chfmt_cfg_reg #(.OSR_W(OSR_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .load     (cfg_load),
        .wdata    (cfg_wdata),
        .os_ratio (os_ratio),
        .cfg      (cfg_s),
        .os_en    (os_en)
    );

    chfmt_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .edge_fall (edge_fall),
        .in_valid  (raw_valid),
        .in_data   (raw_data),
        .cap_valid (cap_valid),
        .cap_data  (cap_data)
    );

    chfmt_core #(.DATA_W(DATA_W)) u_core (
        .raw      (cap_data),
        .cfg      (cfg_s),
        .pkt      (pkt_code_e'(pkt_sel)),
        .fmt_data (fmt_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (cap_valid && cfg_s.ch_en) begin
            out_valid <= 1'b1;
            out_data  <= fmt_data;
        end else begin
            out_valid <= 1'b0;
        end
    end

    assign cfg_q = cfg_pack(cfg_s);

endmodule

// File: rtl/chfmt_chk.sv
module chfmt_chk #(
    parameter int DATA_W = 32,
    parameter int OSR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic [7:0]        cfg_wdata,
    input logic [7:0]        cfg_q,
    input logic              edge_fall,
    input logic [OSR_W-1:0]  os_ratio,
    input logic              os_en,
    input logic              raw_valid,
    input logic [DATA_W-1:0] raw_data,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);

    // R2
    rst_defaults_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg_q == 8'h51 && !out_valid && !os_en));

    // R1
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (cfg_q == ($past(cfg_wdata) & 8'h71)));

    // R8
    ch_off_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_q[0] |=> !out_valid);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !edge_fall && cfg_q[0]) |=> out_valid);

    // R3
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_valid && !edge_fall && cfg_q[0] && !cfg_q[4]) |=> (out_data == $past(raw_data)));

    // R11
    os_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (os_ratio > OSR_W'(1)) |=> os_en);

    // R11
    os_lo_chk: assert property (@(posedge clk) disable iff (rst)
        (os_ratio <= OSR_W'(1)) |=> !os_en);

endmodule

bind chfmt_top chfmt_chk #(.DATA_W(DATA_W), .OSR_W(OSR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_load  (cfg_load),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .edge_fall (edge_fall),
    .os_ratio  (os_ratio),
    .os_en     (os_en),
    .raw_valid (raw_valid),
    .raw_data  (raw_data),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/chfmt_top_tb.sv
`timescale 1ns/1ps
module chfmt_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_q;
    logic        edge_fall = 1'b0;
    logic [1:0]  pkt_sel = 2'd0;
    logic [7:0]  os_ratio = '0;
    logic        os_en;
    logic        raw_valid = 1'b0;
    logic [31:0] raw_data = '0;
    logic        out_valid;
    logic [31:0] out_data;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    chfmt_top #(.DATA_W(32), .OSR_W(8)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_load  (cfg_load),
        .cfg_wdata (cfg_wdata),
        .cfg_q     (cfg_q),
        .edge_fall (edge_fall),
        .pkt_sel   (pkt_sel),
        .os_ratio  (os_ratio),
        .os_en     (os_en),
        .raw_valid (raw_valid),
        .raw_data  (raw_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [31:0] ref_fmt(logic [31:0] r, logic [7:0] c, logic [1:0] p);
        int w;
        logic [63:0] m;
        logic [63:0] v;
        w = (p == 2'd0) ? 20 : (p == 2'd1) ? 24 : 32;
        m = (64'd1 << w) - 64'd1;
        if (!c[4]) return r;
        v = {32'd0, r} & m;
        if (c[5]) v = v ^ (64'd1 << (w - 1));
        if (c[6] && v[w-1]) v = v | ~m;
        return v[31:0];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model, compared on every clock
    logic        m_nv = 1'b0;
    logic [31:0] m_nd = '0;
    logic [7:0]  m_cfg = 8'h51;
    logic        e_v = 1'b0;
    logic [31:0] e_d = '0;
    logic        e_os = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            m_nv <= 1'b0;
            m_nd <= '0;
        end else begin
            m_nv <= raw_valid;
            m_nd <= raw_data;
        end
    end

    always @(posedge clk) begin
        logic        sv;
        logic [31:0] sd;
        sv = edge_fall ? m_nv : raw_valid;
        sd = edge_fall ? m_nd : raw_data;
        if (rst) begin
            m_cfg = 8'h51;
            e_v   = 1'b0;
            e_d   = '0;
            e_os  = 1'b0;
        end else begin
            if (sv && m_cfg[0]) begin
                e_v = 1'b1;
                e_d = ref_fmt(sd, m_cfg, pkt_sel);
            end else begin
                e_v = 1'b0;
            end
            if (cfg_load) m_cfg = cfg_wdata & 8'h71;
            e_os = (os_ratio > 8'd1);
        end
        #2;
        if (!done) begin
            check("R8 R9 out_valid", {31'd0, out_valid}, {31'd0, e_v});
            check("R3 R4 R5 R6 R7 R10 out_data", out_data, e_d);
            check("R1 R2 cfg_q", {24'd0, cfg_q}, {24'd0, m_cfg});
            check("R11 os_en", {31'd0, os_en}, {31'd0, e_os});
        end
    end

    task automatic set_cfg(input logic [7:0] w);
        @(posedge clk); #1;
        cfg_load = 1'b1; cfg_wdata = w;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        #1;
    endtask

    task automatic send(input logic [31:0] d);
        @(posedge clk); #1;
        raw_data = d; raw_valid = 1'b1;
        @(posedge clk); #1;
        raw_valid = 1'b0;
        #1;
    endtask

    task automatic send_split(input logic [31:0] a, input logic [31:0] b);
        @(posedge clk); #1;
        raw_data = a; raw_valid = 1'b1;
        #2;
        raw_data = b;
        @(posedge clk); #1;
        raw_valid = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #2;
        // R2 reset state
        check("R2 cfg_q reset", {24'd0, cfg_q}, 32'h51);
        check("R2 out_valid reset", {31'd0, out_valid}, 32'd0);
        check("R2 out_data reset", out_data, 32'd0);
        check("R2 os_en reset", {31'd0, os_en}, 32'd0);

        // R4 R6: 20-bit packet, sign extension on
        send(32'h000F_FFFF);
        check("R6 sext 20-bit negative", out_data, 32'hFFFF_FFFF);
        send(32'hABC1_2345);
        check("R4 20-bit field positive", out_data, 32'h0001_2345);

        // R9 latency
        @(posedge clk); #1;
        raw_data = 32'h0000_0777; raw_valid = 1'b1;
        #1 check("R9 no output before edge", {31'd0, out_valid}, 32'd0);
        @(posedge clk); #1;
        raw_valid = 1'b0;
        #1 check("R9 valid one edge later", {31'd0, out_valid}, 32'd1);
        check("R9 data one edge later", out_data, 32'h0000_0777);
        @(posedge clk); #2;
        check("R9 valid single cycle", {31'd0, out_valid}, 32'd0);

        // R1 control word layout
        set_cfg(8'hFF);
        check("R1 undefined bits read zero", {24'd0, cfg_q}, 32'h71);

        // R5 offset binary, 20-bit
        set_cfg(8'h71);
        send(32'h0008_0000);
        check("R5 obin midscale to zero", out_data, 32'h0000_0000);
        send(32'h0000_0001);
        check("R5 obin low code negative", out_data, 32'hFFF8_0001);

        // R6 zero fill, 24-bit
        set_cfg(8'h11);
        @(posedge clk); #1 pkt_sel = 2'd1;
        send(32'hFF80_0000);
        check("R6 zero fill 24-bit", out_data, 32'h0080_0000);

        // R3 pass-through ignores type and sign bits
        set_cfg(8'h61);
        send(32'h1234_5678);
        check("R3 format off passthrough", out_data, 32'h1234_5678);

        // R4 R5 32-bit and reserved code
        set_cfg(8'h51);
        @(posedge clk); #1 pkt_sel = 2'd2;
        send(32'h8000_0000);
        check("R4 32-bit sext no-op", out_data, 32'h8000_0000);
        set_cfg(8'h71);
        @(posedge clk); #1 pkt_sel = 2'd3;
        send(32'h0000_0001);
        check("R4 code 3 acts as 32-bit", out_data, 32'h8000_0001);

        // R8 R10 channel disabled
        set_cfg(8'h50);
        send(32'h0000_1234);
        check("R8 disabled no valid", {31'd0, out_valid}, 32'd0);
        check("R10 disabled data held", out_data, 32'h8000_0001);

        // R7 edge select
        set_cfg(8'h11);
        @(posedge clk); #1 pkt_sel = 2'd2; edge_fall = 1'b0;
        send_split(32'h1111_1111, 32'h2222_2222);
        check("R7 rising edge capture", out_data, 32'h2222_2222);
        @(posedge clk); #1 edge_fall = 1'b1;
        send_split(32'h3333_3333, 32'h4444_4444);
        check("R7 falling edge capture", out_data, 32'h3333_3333);
        check("R7 falling valid", {31'd0, out_valid}, 32'd1);
        @(posedge clk); #1 edge_fall = 1'b0;

        // R11 oversampling flag
        os_ratio = 8'd0; @(posedge clk); #2;
        check("R11 ratio 0", {31'd0, os_en}, 32'd0);
        #1 os_ratio = 8'd2; @(posedge clk); #2;
        check("R11 ratio 2", {31'd0, os_en}, 32'd1);
        #1 os_ratio = 8'd1; @(posedge clk); #2;
        check("R11 ratio 1", {31'd0, os_en}, 32'd0);
        #1 os_ratio = 8'd255; @(posedge clk); #2;
        check("R11 ratio 255", {31'd0, os_en}, 32'd1);

        // mixed traffic, compared by the model every clock
        for (int n = 0; n < 400; n++) begin
            @(posedge clk); #1;
            raw_data  = $urandom;
            raw_valid = $urandom_range(0, 1);
            pkt_sel   = 2'($urandom_range(0, 3));
            edge_fall = $urandom_range(0, 1);
            os_ratio  = 8'($urandom_range(0, 3));
            if (n % 23 == 0) begin
                cfg_load  = 1'b1;
                cfg_wdata = 8'($urandom);
            end else begin
                cfg_load = 1'b0;
            end
        end
        @(posedge clk); #1;
        cfg_load = 1'b0; raw_valid = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        finish_run();
    end

endmodule